// File: doc/BRIEF.md
# Virtqueue Used-Ring Completion Writer

This engine finishes one device request on a split virtqueue. It is given the head index of a descriptor chain, the index of the first device-writable descriptor in that chain and the total length of a reply. It copies the reply bytes, which it pulls one at a time from a show-ahead source, into the chain's writable buffers through a memory port. It then publishes a used-ring element, advances the used index and pulses an interrupt request toward the register front end.

The writable part of the chain is walked twice. The first walk checks every descriptor and sums the buffer capacity. The second walk copies the bytes. A malformed chain, or a reply that does not fit, is therefore refused before any byte reaches memory. A refusal sets a sticky error flag that only a device reset clears.

The memory port reads aligned 32-bit little-endian words, with one cycle of latency. It writes with per-byte strobes. Descriptor i sits at ring base + 16·i. Within a descriptor, the buffer address low word is at +0 and the length at +8. The word at +12 carries the flags in bits 15:0 and the next index in bits 31:16. Flag bit 0 means "a next descriptor follows" and flag bit 1 means "device-writable". The ring base is the page frame number shifted left by 12.

Top module: `vq_cpl_writer`

## Requirements
- R1: After reset, busy, irq and err are low, and neither mem_rd nor mem_wr is asserted while the engine is idle.
- R2: The used ring starts at base + 18·size + 4, rounded up to a multiple of 4096. The engine reads the 16-bit used index from bits 31:16 of the word at that address. It writes back the index plus 1, modulo 2^16, with strobe 4'b1100.
- R3: The used element is at used ring + 4 + (old index & (size−1))·8. Its first word holds the chain head index, zero-extended, and its second word holds the reply length. A zero-length reply still completes, with length 0.
- R4: Reply bytes fill the writable buffers in chain order. Each buffer is filled from its address word (+0) upward, and filling moves to the next buffer once the current buffer's length (+8) is used. Zero-length buffers are skipped. Memory past the last reply byte is left unchanged. Each byte is written to word address[31:2], with strobe bit address[1:0] set.
- R5: If the reply is longer than the summed writable capacity, err is set. No reply byte is written, the used index and element are unchanged, and no irq is raised.
- R6: If any descriptor reached on the writable walk lacks flag bit 1, the request is aborted in the same way as R5. This holds even when the earlier buffers alone could hold the reply.
- R7: A job presented with job_wr_valid low is dropped. busy stays low, there is no memory access, no irq is raised and err is unchanged.
- R8: busy is high from the cycle after an accepted start through a single-cycle irq pulse. The irq pulse follows the used-element write, and busy is low after the pulse.
- R9: job_start while busy is ignored. The running job completes with its own head index.
- R10: err stays set across later jobs until dev_reset, which clears it and returns the engine to idle.
- R11: The request is aborted as in R5 when a writable index (first or next) is not below size, or when a chain links more than size descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_reset | input | 1 | Device reset: clears err, forces idle |
| job_start | input | 1 | Start a completion (taken only when idle) |
| job_head | input | IW | Chain head index for the used element |
| job_wr_valid | input | 1 | Chain has a writable part |
| job_wr_idx | input | IW | Index of first writable descriptor |
| job_len | input | LW | Total reply length in bytes |
| ring_pfn | input | AW-12 | Ring page frame number |
| ring_size | input | IW | Queue size (power of two) |
| rep_data | input | 8 | Current reply byte (show-ahead) |
| rep_take | output | 1 | Consume the current reply byte |
| mem_rd | output | 1 | Word read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | AW | Byte address |
| mem_wstrb | output | 4 | Write byte strobes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| busy | output | 1 | Job in progress |
| irq | output | 1 | One-cycle completion interrupt pulse |
| err | output | 1 | Sticky abort flag |

## Verification
The bench spreads a reply over three buffers, one of them zero length. An engine that does not move on at a buffer boundary would overrun the first buffer. One that mishandles an empty buffer would stall there or write into it. The bench starts from a used index of 0xFFFF to check the 16-bit wrap and the slot mask. A wrong mask or ring placement would leave the element in the wrong slot or page. It also builds a chain whose read-only descriptor follows a writable buffer that is already large enough. A single-pass design would write the bytes and complete, where a correct one refuses. Overflow, a self-looping chain, an out-of-range index, a dropped job and a start issued while busy each have a checkable effect in memory or on irq and err.

// File: rtl/vqcw_pkg.sv
package vqcw_pkg;
  localparam int PG_BITS   = 12;
  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / 8;
  localparam int OFF_ADDR  = 0;
  localparam int OFF_LEN   = 8;
  localparam int OFF_CTRL  = 12;
  localparam int F_NEXT    = 0;
  localparam int F_WRITE   = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RW, S_COPY, S_UWR, S_E0, S_E1, S_IRQ
  } state_t;

  typedef enum logic [1:0] {
    ST_CTRL, ST_LEN, ST_ADDR, ST_UIDX
  } step_t;
endpackage

// File: rtl/vqcw_ring_geom.sv
module vqcw_ring_geom
  import vqcw_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  localparam int PW = AW - PG_BITS
) (
  input  logic [PW-1:0] pfn,
  input  logic [IW-1:0] size,
  output logic [AW-1:0] desc_base,
  output logic [AW-1:0] used_base
);
  logic [AW-1:0] sz;
  logic [AW-1:0] raw;

  assign desc_base = {pfn, {PG_BITS{1'b0}}};
  assign sz        = AW'(size);
  // descriptor table, then avail flags/idx/ring, then round up to a page
  assign raw       = desc_base + (sz << 4) + (sz << 1) + AW'(4)
                   + AW'((1 << PG_BITS) - 1);
  assign used_base = {raw[AW-1:PG_BITS], {PG_BITS{1'b0}}};
endmodule

// File: rtl/vqcw_byte_lane.sv
module vqcw_byte_lane #(
  parameter int LANES = 4,
  localparam int SW = $clog2(LANES)
) (
  input  logic [SW-1:0]      sel,
  input  logic [7:0]         din,
  output logic [LANES-1:0]   strb,
  output logic [8*LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb[g]         = (sel == SW'(g));
    assign dout[8*g +: 8]  = din;
  end
endmodule

// File: rtl/vq_cpl_writer.sv
module vq_cpl_writer
  import vqcw_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int LW = 32,
  localparam int PW = AW - PG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_reset,
  input  logic              job_start,
  input  logic [IW-1:0]     job_head,
  input  logic              job_wr_valid,
  input  logic [IW-1:0]     job_wr_idx,
  input  logic [LW-1:0]     job_len,
  input  logic [PW-1:0]     ring_pfn,
  input  logic [IW-1:0]     ring_size,
  input  logic [7:0]        rep_data,
  output logic              rep_take,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_wstrb,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              irq,
  output logic              err
);
  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  state_t        state_q, state_d;
  step_t         step_q, step_d;
  logic          ph2_q, ph2_d;
  logic [IW-1:0] cur_q, cur_d, first_q, first_d, nxt_q, nxt_d;
  logic          more_q, more_d;
  logic [IW-1:0] hops_q, hops_d;
  logic [LW:0]   cap_q, cap_d;
  logic [LW-1:0] blen_q, blen_d, ptr_q, ptr_d, rem_q, rem_d, len_q, len_d;
  logic [AW-1:0] baddr_q, baddr_d;
  logic [IW-1:0] uidx_q, uidx_d, head_q, head_d, size_q, size_d;
  logic [AW-1:0] dbase_q, dbase_d, ubase_q, ubase_d;
  logic          err_q, err_d;

  logic [AW-1:0] geo_desc, geo_used;
  vqcw_ring_geom #(.AW(AW), .IW(IW)) u_geom (
    .pfn(ring_pfn), .size(ring_size),
    .desc_base(geo_desc), .used_base(geo_used)
  );

  logic [AW-1:0]     wr_byte_addr;
  logic [LANES-1:0]  lane_strb;
  logic [WORD_W-1:0] lane_data;
  assign wr_byte_addr = baddr_q + AW'(ptr_q);
  vqcw_byte_lane #(.LANES(LANES)) u_lane (
    .sel(wr_byte_addr[$clog2(LANES)-1:0]), .din(rep_data),
    .strb(lane_strb), .dout(lane_data)
  );

  logic [AW-1:0] desc_addr, elem_addr;
  logic [AW-1:0] step_off;
  logic [LW+1:0] cap_sum;
  logic [IW-1:0] rd_next;
  logic [15:0]   rd_flags;
  logic          abort;

  always_comb begin
    case (step_q)
      ST_CTRL: step_off = AW'(OFF_CTRL);
      ST_LEN:  step_off = AW'(OFF_LEN);
      default: step_off = AW'(OFF_ADDR);
    endcase
  end
  assign desc_addr = dbase_q + (AW'(cur_q) << 4) + step_off;
  assign elem_addr = ubase_q + AW'(4) + (AW'(uidx_q & (size_q - IW'(1))) << 3);
  assign cap_sum   = {1'b0, cap_q} + (LW+2)'(mem_rdata);
  assign rd_next   = IW'(mem_rdata[31:16]);
  assign rd_flags  = mem_rdata[15:0];

  always_comb begin
    state_d = state_q;  step_d  = step_q;   ph2_d   = ph2_q;
    cur_d   = cur_q;    first_d = first_q;  nxt_d   = nxt_q;
    more_d  = more_q;   hops_d  = hops_q;   cap_d   = cap_q;
    blen_d  = blen_q;   ptr_d   = ptr_q;    rem_d   = rem_q;
    len_d   = len_q;    baddr_d = baddr_q;  uidx_d  = uidx_q;
    head_d  = head_q;   size_d  = size_q;   dbase_d = dbase_q;
    ubase_d = ubase_q;  err_d   = err_q;
    abort     = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wstrb = '0;
    mem_wdata = '0;
    rep_take  = 1'b0;
    irq       = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (job_start && job_wr_valid) begin
          head_d  = job_head;
          len_d   = job_len;
          rem_d   = job_len;
          size_d  = ring_size;
          dbase_d = geo_desc;
          ubase_d = geo_used;
          cur_d   = job_wr_idx;
          first_d = job_wr_idx;
          ph2_d   = 1'b0;
          hops_d  = '0;
          cap_d   = '0;
          step_d  = ST_CTRL;
          if (job_wr_idx >= ring_size) abort = 1'b1;
          else                         state_d = S_RD;
        end
      end
      S_RD: begin
        mem_rd   = 1'b1;
        mem_addr = (step_q == ST_UIDX) ? ubase_q : desc_addr;
        state_d  = S_RW;
      end
      S_RW: begin
        case (step_q)
          ST_CTRL: begin
            if (!rd_flags[F_WRITE]) begin
              abort = 1'b1;
            end else begin
              nxt_d   = rd_next;
              more_d  = rd_flags[F_NEXT];
              step_d  = ST_LEN;
              state_d = S_RD;
            end
          end
          ST_LEN: begin
            if (ph2_q) begin
              blen_d  = LW'(mem_rdata);
              step_d  = ST_ADDR;
              state_d = S_RD;
            end else begin
              cap_d = cap_sum[LW+1] ? '1 : cap_sum[LW:0];
              if (more_q) begin
                if (nxt_q >= size_q || hops_q == size_q - IW'(1)) begin
                  abort = 1'b1;
                end else begin
                  cur_d   = nxt_q;
                  hops_d  = hops_q + IW'(1);
                  step_d  = ST_CTRL;
                  state_d = S_RD;
                end
              end else if (cap_d < {1'b0, len_q}) begin
                abort = 1'b1;
              end else begin
                ph2_d   = 1'b1;
                cur_d   = first_q;
                step_d  = ST_CTRL;
                state_d = S_RD;
              end
            end
          end
          ST_ADDR: begin
            baddr_d = AW'(mem_rdata);
            ptr_d   = '0;
            state_d = S_COPY;
          end
          default: begin
            uidx_d  = IW'(mem_rdata[31:16]);
            state_d = S_UWR;
          end
        endcase
      end
      S_COPY: begin
        if (rem_q == '0) begin
          step_d  = ST_UIDX;
          state_d = S_RD;
        end else if (ptr_q == blen_q) begin
          if (more_q) begin
            cur_d   = nxt_q;
            step_d  = ST_CTRL;
            state_d = S_RD;
          end else begin
            abort = 1'b1;
          end
        end else begin
          mem_wr    = 1'b1;
          mem_addr  = wr_byte_addr;
          mem_wstrb = lane_strb;
          mem_wdata = lane_data;
          rep_take  = 1'b1;
          ptr_d     = ptr_q + LW'(1);
          rem_d     = rem_q - LW'(1);
        end
      end
      S_UWR: begin
        mem_wr    = 1'b1;
        mem_addr  = ubase_q;
        mem_wstrb = 4'b1100;
        mem_wdata = {16'(uidx_q + IW'(1)), 16'h0000};
        state_d   = S_E0;
      end
      S_E0: begin
        mem_wr    = 1'b1;
        mem_addr  = elem_addr;
        mem_wstrb = '1;
        mem_wdata = WORD_W'(head_q);
        state_d   = S_E1;
      end
      S_E1: begin
        mem_wr    = 1'b1;
        mem_addr  = elem_addr + AW'(4);
        mem_wstrb = '1;
        mem_wdata = WORD_W'(len_q);
        state_d   = S_IRQ;
      end
      S_IRQ: begin
        irq     = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase

    if (abort) begin
      err_d   = 1'b1;
      state_d = S_IDLE;
    end
    if (dev_reset) begin
      err_d   = 1'b0;
      state_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      state_q <= S_IDLE;  step_q  <= ST_CTRL; ph2_q   <= 1'b0;
      cur_q   <= '0;      first_q <= '0;      nxt_q   <= '0;
      more_q  <= 1'b0;    hops_q  <= '0;      cap_q   <= '0;
      blen_q  <= '0;      ptr_q   <= '0;      rem_q   <= '0;
      len_q   <= '0;      baddr_q <= '0;      uidx_q  <= '0;
      head_q  <= '0;      size_q  <= '0;      dbase_q <= '0;
      ubase_q <= '0;      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;  step_q  <= step_d;   ph2_q   <= ph2_d;
      cur_q   <= cur_d;    first_q <= first_d;  nxt_q   <= nxt_d;
      more_q  <= more_d;   hops_q  <= hops_d;   cap_q   <= cap_d;
      blen_q  <= blen_d;   ptr_q   <= ptr_d;    rem_q   <= rem_d;
      len_q   <= len_d;    baddr_q <= baddr_d;  uidx_q  <= uidx_d;
      head_q  <= head_d;   size_q  <= size_d;   dbase_q <= dbase_d;
      ubase_q <= ubase_d;  err_q   <= err_d;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign err  = err_q;
endmodule

// File: rtl/vq_cpl_writer_chk.sv
module vq_cpl_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_reset,
  input logic       busy,
  input logic       irq,
  input logic       err,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [3:0] mem_wstrb,
  input logic       rep_take
);
  // R8
  irq_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !busy);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !dev_reset) |=> err);
  // R5
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!irq && !busy));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));
  // R4
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_take |-> (mem_wr && $onehot(mem_wstrb)));
endmodule

bind vq_cpl_writer vq_cpl_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .busy(busy),
  .irq(irq), .err(err), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wstrb(mem_wstrb), .rep_take(rep_take)
);

// File: tb/vq_cpl_writer_bench.sv
`timescale 1ns/1ps
module vq_cpl_writer_bench;
  localparam logic [31:0] WIN   = 32'h1000;
  localparam logic [31:0] USED  = 32'h2000;
  localparam logic [15:0] FW    = 16'h0002;
  localparam logic [15:0] FN    = 16'h0001;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, dev_reset, job_start, job_wr_valid;
  logic [15:0] job_head, job_wr_idx, ring_size;
  logic [31:0] job_len;
  logic [19:0] ring_pfn;
  logic [7:0]  rep_data;
  logic        rep_take, mem_rd, mem_wr, busy, irq, err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;

  vq_cpl_writer u_vq_cpl_writer (
    .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .job_start(job_start),
    .job_head(job_head), .job_wr_valid(job_wr_valid), .job_wr_idx(job_wr_idx),
    .job_len(job_len), .ring_pfn(ring_pfn), .ring_size(ring_size),
    .rep_data(rep_data), .rep_take(rep_take), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .irq(irq), .err(err)
  );

  logic [31:0] mem [0:2047];
  int rp = 0, irq_cnt = 0, acc_cnt = 0;
  int n_cmp = 0, n_bad = 0;

  function automatic int widx(input logic [31:0] a);
    return int'((a - WIN) >> 2) & 2047;
  endfunction
  function automatic logic [7:0] pat(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction
  assign rep_data = pat(rp);

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[widx(mem_addr)];
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_wstrb[b]) mem[widx(mem_addr)][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (rep_take) rp <= rp + 1;
    if (irq) irq_cnt <= irq_cnt + 1;
    if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(input logic [31:0] a);
    return mem[widx(a)][8*a[1:0] +: 8];
  endfunction
  task automatic put_desc(input int i, input logic [31:0] a, input logic [31:0] l,
                          input logic [15:0] f, input logic [15:0] nx);
    logic [31:0] d;
    d = WIN + 32'(16 * i);
    mem[widx(d)] = a; mem[widx(d + 4)] = 0;
    mem[widx(d + 8)] = l; mem[widx(d + 12)] = {nx, f};
  endtask
  task automatic fill(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i += 4) mem[widx(a + 32'(i))] = 32'hEEEEEEEE;
  endtask
  task automatic set_uidx(input logic [15:0] v);
    mem[widx(USED)] = {v, 16'h0};
  endtask
  function automatic logic [15:0] uidx();
    return mem[widx(USED)][31:16];
  endfunction
  function automatic logic [31:0] slot_w(input int s, input int w);
    return mem[widx(USED + 32'(4 + 8 * s + 4 * w))];
  endfunction
  function automatic int bytes_bad(input logic [31:0] a, input int n, input int k0);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rdb(a + 32'(i)) !== pat(k0 + i)) bad++;
    return bad;
  endfunction

  task automatic run_job(input logic [15:0] head, input logic wv, input logic [15:0] wi,
                         input logic [31:0] len, output logic saw_busy);
    @(negedge clk);
    job_start = 1; job_head = head; job_wr_valid = wv; job_wr_idx = wi; job_len = len;
    @(negedge clk);
    saw_busy = busy;
    job_start = 0;
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic pulse_dev_reset();
    @(negedge clk); dev_reset = 1;
    @(negedge clk); dev_reset = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 err", 32'(err), 0);
    check("R1 mem access", 32'(mem_rd | mem_wr), 0);
  endtask

  task automatic t_single();
    logic sb; int k0, i0;
    put_desc(3, 32'h1800, 16, FW, 0); fill(32'h1800, 32); set_uidx(5);
    k0 = rp; i0 = irq_cnt;
    run_job(2, 1, 3, 10, sb);
    check("R8 busy after start", 32'(sb), 1);
    check("R4 single buffer bytes", 32'(bytes_bad(32'h1800, 10, k0)), 0);
    check("R4 byte past reply", 32'(rdb(32'h180A)), 32'hEE);
    check("R2 used index +1", 32'(uidx()), 6);
    check("R3 slot head", slot_w(5, 0), 2);
    check("R3 slot len", slot_w(5, 1), 10);
    check("R8 one irq pulse", 32'(irq_cnt - i0), 1);
    check("R8 busy low after", 32'(busy), 0);
  endtask

  task automatic t_spill();
    logic sb; int k0;
    put_desc(3, 32'h1840, 3, FW | FN, 5);
    put_desc(5, 32'h1900, 0, FW | FN, 1);
    put_desc(1, 32'h1880, 8, FW, 0);
    fill(32'h1840, 16); fill(32'h1880, 16); fill(32'h1900, 8); set_uidx(16'hFFFF);
    k0 = rp;
    run_job(4, 1, 3, 9, sb);
    check("R4 spill first buffer", 32'(bytes_bad(32'h1840, 3, k0)), 0);
    check("R4 first buffer bound", 32'(rdb(32'h1843)), 32'hEE);
    check("R4 zero length buffer untouched", 32'(rdb(32'h1900)), 32'hEE);
    check("R4 spill third buffer", 32'(bytes_bad(32'h1880, 6, k0 + 3)), 0);
    check("R4 third buffer tail", 32'(rdb(32'h1886)), 32'hEE);
    check("R2 used index wrap", 32'(uidx()), 0);
    check("R3 masked slot head", slot_w(7, 0), 4);
    check("R3 masked slot len", slot_w(7, 1), 9);
  endtask

  task automatic t_overflow_and_sticky();
    logic sb; int i0;
    put_desc(3, 32'h1800, 8, FW, 0); fill(32'h1800, 16); set_uidx(2);
    mem[widx(USED + 20)] = 32'hDEAD0001; i0 = irq_cnt;
    run_job(6, 1, 3, 9, sb);
    check("R5 err on overflow", 32'(err), 1);
    check("R5 no byte written", 32'(rdb(32'h1800)), 32'hEE);
    check("R5 index unchanged", 32'(uidx()), 2);
    check("R5 element untouched", slot_w(2, 0), 32'hDEAD0001);
    check("R5 no irq", 32'(irq_cnt - i0), 0);
    run_job(7, 1, 3, 0, sb);
    check("R3 zero length completes idx", 32'(uidx()), 3);
    check("R3 zero length head", slot_w(2, 0), 7);
    check("R3 zero length len", slot_w(2, 1), 0);
    check("R10 err sticky across job", 32'(err), 1);
    pulse_dev_reset();
    check("R10 dev reset clears err", 32'(err), 0);
  endtask

  task automatic t_readonly();
    logic sb; int i0;
    put_desc(3, 32'h1800, 4, FW | FN, 4);
    put_desc(4, 32'h1880, 16, 16'h0000, 0);
    fill(32'h1800, 8); set_uidx(9); i0 = irq_cnt;
    run_job(1, 1, 3, 2, sb);
    check("R6 err on readonly", 32'(err), 1);
    check("R6 no byte written", 32'(rdb(32'h1800)), 32'hEE);
    check("R6 index unchanged", 32'(uidx()), 9);
    check("R6 no irq", 32'(irq_cnt - i0), 0);
    pulse_dev_reset();
  endtask

  task automatic t_no_writable();
    logic sb; int a0, i0;
    set_uidx(4); a0 = acc_cnt; i0 = irq_cnt;
    run_job(2, 0, 3, 5, sb);
    check("R7 no busy", 32'(sb), 0);
    check("R7 no memory access", 32'(acc_cnt - a0), 0);
    check("R7 no irq", 32'(irq_cnt - i0), 0);
    check("R7 err unchanged", 32'(err), 0);
    check("R7 index unchanged", 32'(uidx()), 4);
  endtask

  task automatic t_busy_start();
    int i0;
    put_desc(3, 32'h1800, 16, FW, 0); set_uidx(1); i0 = irq_cnt;
    @(negedge clk);
    job_start = 1; job_head = 2; job_wr_valid = 1; job_wr_idx = 3; job_len = 4;
    @(negedge clk); job_head = 6; job_len = 1;
    @(negedge clk); job_start = 0;
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    @(negedge clk);
    check("R9 head of first job", slot_w(1, 0), 2);
    check("R9 len of first job", slot_w(1, 1), 4);
    check("R9 single completion", 32'(irq_cnt - i0), 1);
  endtask

  task automatic t_guard();
    logic sb;
    put_desc(3, 32'h1800, 1, FW | FN, 3); set_uidx(0);
    run_job(3, 1, 3, 50, sb);
    check("R11 looping chain aborts", 32'(err), 1);
    check("R11 loop index unchanged", 32'(uidx()), 0);
    pulse_dev_reset();
    run_job(3, 1, 8, 1, sb);
    check("R11 index beyond size aborts", 32'(err), 1);
    pulse_dev_reset();
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; dev_reset = 0; job_start = 0; job_wr_valid = 0;
    job_head = 0; job_wr_idx = 0; job_len = 0;
    ring_pfn = 20'h1; ring_size = 16'd8;
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_spill();
    t_overflow_and_sticky();
    t_readonly();
    t_no_writable();
    t_busy_start();
    t_guard();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule